// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits between a byte-wide bus write port and the embedded program/erase controller of a flash array. Each bus write reaches it as one valid pulse carrying an address and a data byte. The block reads the stream of writes as multi-cycle commands. Every command except the single-write reset must begin with two unlock writes: data AAh at address 555h, then data 55h at address 2AAh. From these commands the block sets the device mode, which selects what array reads return: normal data, identification codes, or normal data with the shortened bypass command set. It also gives the controller one-clock requests to program a byte, to erase the whole chip, or to cancel. A cancel stops a running chip erase and clears a pending error.

The controller returns a busy flag and an error flag. While a byte program is in progress, the decoder ignores every write. While a chip erase is in progress, or while an error is pending, only a reset is acted on. Bypass mode lets a programmer write a byte with two writes instead of four. The array, the operation timing and the read path are outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after reset, `mode` is 0 (read), all three pulse outputs are low, and `pgm_addr`/`pgm_data` are zero.
- R2: Command cycles are matched on address bits 10..0 only. Bits above 10 have no effect on whether a command is recognised.
- R3: The writes AAh@555h, 55h@2AAh, A0h@555h, then any address and data raise `pgm_start` for one clock, one cycle after the fourth write. That write's address and data appear on `pgm_addr`/`pgm_data`, and `mode` becomes 0.
- R4: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `erase_start` one cycle after the sixth write, and `mode` becomes 0.
- R5: A reset is either one write of F0h at any address, or AAh@555h, 55h@2AAh, F0h at any address. Outside bypass mode it sets `mode` to 0 and pulses `cancel`.
- R6: AAh@555h, 55h@2AAh, 90h@555h sets `mode` to 1 (identification). It stays there through idle cycles until another command or a breaking write arrives.
- R7: Outside bypass mode, a write that does not continue a valid sequence sets `mode` to 0 and discards the partial sequence. With no write, `mode` never changes.
- R8: AAh@555h, 55h@2AAh, 20h@555h sets `mode` to 2 (bypass). In bypass mode, A0h at any address followed by any write programs that byte (`pgm_start` as in R3, `mode` stays 2). 90h then 00h, both at any address, return `mode` to 0. Every other write is ignored, including F0h when no error is pending.
- R9: While `ctl_busy` is high after a program request, every write is ignored: no pulse, no mode change.
- R10: While `ctl_busy` is high after an erase request, a reset (either form) pulses `cancel`. All other commands are ignored.
- R11: While `ctl_error` is high, only a reset is honoured. In bypass mode, F0h at any address pulses `cancel` and `mode` stays 2.
- R12: `pgm_start`, `erase_start` and `cancel` are single-clock pulses and never two at once. A write in the same cycle that `ctl_busy` is first low is handled as after completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle pulse marking a bus write |
| wr_addr | input | ADDR_W (16) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| ctl_busy | input | 1 | Controller is running an operation |
| ctl_error | input | 1 | Controller reports a failed operation |
| mode | output | 2 | 0 read, 1 identification, 2 bypass |
| pgm_start | output | 1 | One-clock byte program request |
| pgm_addr | output | ADDR_W (16) | Latched program address |
| pgm_data | output | DATA_W (8) | Latched program data |
| erase_start | output | 1 | One-clock chip erase request |
| cancel | output | 1 | One-clock abort / error clear |

## Verification
All results are registered. A pulse, a latched program address or a mode change therefore shows up one clock after the rising edge that captured the completing write, and it lasts exactly that one clock. The bench changes inputs on falling edges. It checks each result at the falling edge right after the capturing edge, so every pulse is seen in its only valid cycle. A behavioural model keeps a queue of the writes still pending. It updates on each capturing edge and is compared with every output at every falling edge, so a pulse that comes early, late, or twice is reported. The busy-release corner is driven by dropping `ctl_busy` and presenting the write at the same falling edge.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
package fcd_pkg;

    typedef enum logic [1:0] {
        MODE_READ   = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_BYPASS = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_ADDR,
        ST_ER3,
        ST_ER4,
        ST_ER5,
        ST_BYP_PGM,
        ST_BYP_EXIT
    } step_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PGM,
        OP_ERASE
    } op_e;

    localparam int NCODE = 9;
    localparam int C_AA = 0;
    localparam int C_55 = 1;
    localparam int C_A0 = 2;
    localparam int C_80 = 3;
    localparam int C_10 = 4;
    localparam int C_90 = 5;
    localparam int C_20 = 6;
    localparam int C_F0 = 7;
    localparam int C_00 = 8;

    function automatic logic [7:0] code_val(input int idx);
        case (idx)
            C_AA:    code_val = 8'hAA;
            C_55:    code_val = 8'h55;
            C_A0:    code_val = 8'hA0;
            C_80:    code_val = 8'h80;
            C_10:    code_val = 8'h10;
            C_90:    code_val = 8'h90;
            C_20:    code_val = 8'h20;
            C_F0:    code_val = 8'hF0;
            default: code_val = 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic             at_lead;
        logic             at_mid;
        logic [NCODE-1:0] hit;
    } wr_class_t;

endpackage

// File: rtl/fcd_classify.sv
`timescale 1ns/1ps
module fcd_classify
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CMP_W  = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wr_class_t         cls
);
    localparam logic [CMP_W-1:0] LEAD_ADDR = CMP_W'(12'h555);
    localparam logic [CMP_W-1:0] MID_ADDR  = CMP_W'(12'h2AA);

    // only the low CMP_W address bits take part in matching
    assign cls.at_lead = (addr[CMP_W-1:0] == LEAD_ADDR);
    assign cls.at_mid  = (addr[CMP_W-1:0] == MID_ADDR);

    generate
        for (genvar i = 0; i < NCODE; i++) begin : g_code
            assign cls.hit[i] = (data == DATA_W'(code_val(i)));
        end
    endgenerate

endmodule

// File: rtl/fcd_sequencer.sv
`timescale 1ns/1ps
module fcd_sequencer
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  wr_class_t         cls,
    input  logic              ctl_busy,
    input  logic              ctl_error,
    output logic [1:0]        mode,
    output logic              pgm_start,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              erase_start,
    output logic              cancel
);
    typedef struct packed {
        mode_e             mode;
        step_e             step;
        op_e               op;
        logic              pgm_go;
        logic              erase_go;
        logic              cancel;
        logic [ADDR_W-1:0] pa;
        logic [DATA_W-1:0] pd;
    } state_t;

    state_t q, d;

    logic unl_a, unl_b, is_f0;
    assign unl_a = cls.at_lead && cls.hit[C_AA];
    assign unl_b = cls.at_mid  && cls.hit[C_55];
    assign is_f0 = cls.hit[C_F0];

    always_comb begin
        d          = q;
        d.pgm_go   = 1'b0;
        d.erase_go = 1'b0;
        d.cancel   = 1'b0;
        if (wr_valid) begin
            if (ctl_busy && q.op == OP_PGM) begin
                d = d;  // program in flight: write dropped
            end else if (ctl_busy || ctl_error) begin
                if (q.mode == MODE_BYPASS) begin
                    d.cancel = is_f0;
                    d.step   = ST_IDLE;
                end else begin
                    unique case (q.step)
                        ST_IDLE: begin
                            if (is_f0) begin
                                d.cancel = 1'b1;
                                d.mode   = MODE_READ;
                                d.step   = ST_IDLE;
                            end else begin
                                d.step = unl_a ? ST_UNL1 : ST_IDLE;
                            end
                        end
                        ST_UNL1: d.step = unl_b ? ST_UNL2 : ST_IDLE;
                        ST_UNL2: begin
                            d.step = ST_IDLE;
                            if (is_f0) begin
                                d.cancel = 1'b1;
                                d.mode   = MODE_READ;
                            end
                        end
                        default: d.step = ST_IDLE;
                    endcase
                end
            end else if (q.mode == MODE_BYPASS) begin
                unique case (q.step)
                    ST_IDLE: begin
                        if (cls.hit[C_A0])      d.step = ST_BYP_PGM;
                        else if (cls.hit[C_90]) d.step = ST_BYP_EXIT;
                        else                    d.step = ST_IDLE;
                    end
                    ST_BYP_PGM: begin
                        d.pgm_go = 1'b1;
                        d.pa     = wr_addr;
                        d.pd     = wr_data;
                        d.op     = OP_PGM;
                        d.step   = ST_IDLE;
                    end
                    ST_BYP_EXIT: begin
                        if (cls.hit[C_00]) d.mode = MODE_READ;
                        d.step = ST_IDLE;
                    end
                    default: d.step = ST_IDLE;
                endcase
            end else begin
                // any unmatched write falls back to read mode
                d.mode = MODE_READ;
                d.step = ST_IDLE;
                unique case (q.step)
                    ST_IDLE: begin
                        if (is_f0) begin
                            d.cancel = 1'b1;
                        end else if (unl_a) begin
                            d.mode = q.mode;
                            d.step = ST_UNL1;
                        end
                    end
                    ST_UNL1: begin
                        if (unl_b) begin
                            d.mode = q.mode;
                            d.step = ST_UNL2;
                        end
                    end
                    ST_UNL2: begin
                        if (is_f0) begin
                            d.cancel = 1'b1;
                        end else if (cls.at_lead && cls.hit[C_90]) begin
                            d.mode = MODE_IDENT;
                        end else if (cls.at_lead && cls.hit[C_20]) begin
                            d.mode = MODE_BYPASS;
                        end else if (cls.at_lead && cls.hit[C_A0]) begin
                            d.mode = q.mode;
                            d.step = ST_PGM_ADDR;
                        end else if (cls.at_lead && cls.hit[C_80]) begin
                            d.mode = q.mode;
                            d.step = ST_ER3;
                        end
                    end
                    ST_PGM_ADDR: begin
                        d.pgm_go = 1'b1;
                        d.pa     = wr_addr;
                        d.pd     = wr_data;
                        d.op     = OP_PGM;
                    end
                    ST_ER3: begin
                        if (unl_a) begin
                            d.mode = q.mode;
                            d.step = ST_ER4;
                        end
                    end
                    ST_ER4: begin
                        if (unl_b) begin
                            d.mode = q.mode;
                            d.step = ST_ER5;
                        end
                    end
                    ST_ER5: begin
                        if (cls.at_lead && cls.hit[C_10]) begin
                            d.erase_go = 1'b1;
                            d.op       = OP_ERASE;
                        end
                    end
                    default: d.step = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{mode: MODE_READ, step: ST_IDLE, op: OP_NONE,
                   pgm_go: 1'b0, erase_go: 1'b0, cancel: 1'b0,
                   pa: '0, pd: '0};
        end else begin
            q <= d;
        end
    end

    assign mode        = q.mode;
    assign pgm_start   = q.pgm_go;
    assign pgm_addr    = q.pa;
    assign pgm_data    = q.pd;
    assign erase_start = q.erase_go;
    assign cancel      = q.cancel;

    // R12
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pgm_go || q.erase_go || q.cancel) |=> !(q.pgm_go || q.erase_go || q.cancel));

    // R12
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.pgm_go, q.erase_go, q.cancel}));

    // R9
    pgm_busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && ctl_busy && q.op == OP_PGM)
        |=> (!q.pgm_go && !q.erase_go && !q.cancel && $stable(q.mode)));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(q.mode));

    // R11
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && ctl_error && !cls.hit[C_F0]) |=> (!q.pgm_go && !q.erase_go && !q.cancel));

    // R3
    pgm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pgm_go |-> ($past(wr_valid) && q.pa == $past(wr_addr) && q.pd == $past(wr_data)));

endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CMP_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ctl_busy,
    input  logic              ctl_error,
    output logic [1:0]        mode,
    output logic              pgm_start,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              erase_start,
    output logic              cancel
);
    wr_class_t cls;

    fcd_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_classify (
        .addr (wr_addr),
        .data (wr_data),
        .cls  (cls)
    );

    fcd_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cls         (cls),
        .ctl_busy    (ctl_busy),
        .ctl_error   (ctl_error),
        .mode        (mode),
        .pgm_start   (pgm_start),
        .pgm_addr    (pgm_addr),
        .pgm_data    (pgm_data),
        .erase_start (erase_start),
        .cancel      (cancel)
    );

endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ctl_busy = 1'b0;
    logic        ctl_error = 1'b0;
    logic [1:0]  mode;
    logic        pgm_start, erase_start, cancel;
    logic [15:0] pgm_addr;
    logic [7:0]  pgm_data;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctl_busy(ctl_busy), .ctl_error(ctl_error),
        .mode(mode), .pgm_start(pgm_start), .pgm_addr(pgm_addr),
        .pgm_data(pgm_data), .erase_start(erase_start), .cancel(cancel)
    );

    // behavioural reference: queue of writes still pending in a sequence
    typedef struct { int a; int d; } wr_t;
    wr_t hist[$];
    wr_t w;
    int  m_mode, m_op, m_pg, m_er, m_cn, m_pa, m_pd, n;
    bit  brk;

    function automatic bit hm(int i, int a, int d);
        return hist[i].d == d && (a < 0 || hist[i].a == a);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_op = 0; m_pg = 0; m_er = 0; m_cn = 0;
            m_pa = 0; m_pd = 0; hist.delete();
        end else begin
            m_pg = 0; m_er = 0; m_cn = 0;
            if (wr_valid && !(ctl_busy && m_op == 1)) begin
                w.a = int'(wr_addr) & 'h7FF;
                w.d = int'(wr_data);
                hist.push_back(w);
                n = hist.size();
                if (ctl_busy || ctl_error) begin
                    if (m_mode == 2) begin
                        if (w.d == 'hF0) m_cn = 1;
                        hist.delete();
                    end else if (w.d == 'hF0 && (n == 1 || n == 3)) begin
                        m_cn = 1; m_mode = 0; hist.delete();
                    end else if (!((n == 1 && hm(0, 'h555, 'hAA)) ||
                                   (n == 2 && hm(1, 'h2AA, 'h55)))) begin
                        hist.delete();
                    end
                end else if (m_mode == 2) begin
                    if (n == 1) begin
                        if (!(w.d == 'hA0 || w.d == 'h90)) hist.delete();
                    end else begin
                        if (hist[0].d == 'hA0) begin
                            m_pg = 1; m_pa = int'(wr_addr); m_pd = w.d; m_op = 1;
                        end else if (w.d == 0) begin
                            m_mode = 0;
                        end
                        hist.delete();
                    end
                end else begin
                    brk = 0;
                    case (n)
                        1: if (w.d == 'hF0) begin m_cn = 1; m_mode = 0; hist.delete(); end
                           else if (!hm(0, 'h555, 'hAA)) brk = 1;
                        2: if (!hm(1, 'h2AA, 'h55)) brk = 1;
                        3: if (w.d == 'hF0) begin m_cn = 1; m_mode = 0; hist.delete(); end
                           else if (hm(2, 'h555, 'h90)) begin m_mode = 1; hist.delete(); end
                           else if (hm(2, 'h555, 'h20)) begin m_mode = 2; hist.delete(); end
                           else if (!(hm(2, 'h555, 'hA0) || hm(2, 'h555, 'h80))) brk = 1;
                        4: if (hist[2].d == 'hA0) begin
                               m_pg = 1; m_pa = int'(wr_addr); m_pd = w.d; m_op = 1;
                               m_mode = 0; hist.delete();
                           end else if (!hm(3, 'h555, 'hAA)) brk = 1;
                        5: if (!hm(4, 'h2AA, 'h55)) brk = 1;
                        6: if (hm(5, 'h555, 'h10)) begin
                               m_er = 1; m_op = 2; m_mode = 0; hist.delete();
                           end else brk = 1;
                        default: brk = 1;
                    endcase
                    if (brk) begin m_mode = 0; hist.delete(); end
                end
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp, string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // model comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(mode) == m_mode, cur_req, int'(mode), m_mode, "model mode");
            chk(int'(pgm_start) == m_pg, cur_req, int'(pgm_start), m_pg, "model pgm_start");
            chk(int'(erase_start) == m_er, cur_req, int'(erase_start), m_er, "model erase_start");
            chk(int'(cancel) == m_cn, cur_req, int'(cancel), m_cn, "model cancel");
            chk(int'(pgm_addr) == m_pa && int'(pgm_data) == m_pd, cur_req,
                int'({pgm_addr, pgm_data}), (m_pa << 8) | m_pd, "model pgm addr/data");
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] dt);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = dt;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(mode == 2'd0 && !pgm_start && !erase_start && !cancel, "R1",
            int'({mode, pgm_start, erase_start, cancel}), 0, "reset outputs");
        chk(pgm_addr == 16'h0 && pgm_data == 8'h0, "R1", int'(pgm_addr), 0, "reset latch");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R3";
        unlock(); wr(16'h0555, 8'hA0); wr(16'h1234, 8'h5A);
        chk(pgm_start == 1'b1, "R3", int'(pgm_start), 1, "pgm_start after 4th write");
        chk(pgm_addr == 16'h1234 && pgm_data == 8'h5A, "R3",
            int'({pgm_addr, pgm_data}), 'h12345A, "latched addr/data");
        @(negedge clk);
        chk(pgm_start == 1'b0, "R12", int'(pgm_start), 0, "pgm_start one clock");

        cur_req = "R2";
        wr(16'hF555, 8'hAA); wr(16'hFAAA, 8'h55); wr(16'h8555, 8'hA0); wr(16'hFFFF, 8'hC3);
        chk(pgm_start == 1'b1 && pgm_addr == 16'hFFFF, "R2",
            int'({pgm_start, pgm_addr}), 'h1FFFF, "upper bits ignored");
        wr(16'h0554, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(16'h0001, 8'h01);
        chk(pgm_start == 1'b0, "R2", int'(pgm_start), 0, "low-bit mismatch rejected");

        cur_req = "R4";
        unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h0555, 8'h10);
        chk(erase_start == 1'b1 && mode == 2'd0, "R4",
            int'({erase_start, mode}), 'h4, "erase_start after 6th write");
        @(negedge clk);
        chk(erase_start == 1'b0, "R12", int'(erase_start), 0, "erase_start one clock");

        cur_req = "R5";
        wr(16'h3000, 8'hF0);
        chk(cancel == 1'b1 && mode == 2'd0, "R5", int'({cancel, mode}), 'h4, "single F0 reset");
        unlock(); wr(16'h7777, 8'hF0);
        chk(cancel == 1'b1, "R5", int'(cancel), 1, "three-write reset");

        cur_req = "R6";
        unlock(); wr(16'h0555, 8'h90);
        chk(mode == 2'd1, "R6", int'(mode), 1, "enter identification");
        repeat (6) @(negedge clk);
        chk(mode == 2'd1, "R6", int'(mode), 1, "identification persists");
        wr(16'h0000, 8'hF0);
        chk(mode == 2'd0, "R6", int'(mode), 0, "reset leaves identification");

        cur_req = "R7";
        unlock(); wr(16'h0555, 8'h90);
        wr(16'h0100, 8'h12);
        chk(mode == 2'd0, "R7", int'(mode), 0, "stray write drops identification");
        wr(16'h0555, 8'hAA); wr(16'h02AB, 8'h55); wr(16'h0555, 8'hA0); wr(16'h1111, 8'h22);
        chk(pgm_start == 1'b0 && mode == 2'd0, "R7", int'({pgm_start, mode}), 0,
            "broken unlock gives no program");

        cur_req = "R8";
        unlock(); wr(16'h0555, 8'h20);
        chk(mode == 2'd2, "R8", int'(mode), 2, "enter bypass");
        wr(16'h0000, 8'hA0); wr(16'h0042, 8'h77);
        chk(pgm_start == 1'b1 && pgm_addr == 16'h0042 && pgm_data == 8'h77 && mode == 2'd2,
            "R8", int'({pgm_start, pgm_addr, pgm_data}), 'h100_4277, "bypass program");
        wr(16'h1234, 8'h33);
        chk(mode == 2'd2 && !pgm_start, "R8", int'(mode), 2, "other write ignored in bypass");
        wr(16'h0000, 8'hF0);
        chk(mode == 2'd2 && !cancel, "R8", int'({cancel, mode}), 2, "F0 ignored in bypass");
        wr(16'h0000, 8'h90); wr(16'h0000, 8'h00);
        chk(mode == 2'd0, "R8", int'(mode), 0, "bypass exit");

        cur_req = "R9";
        unlock(); wr(16'h0555, 8'hA0); wr(16'h0500, 8'h11);
        ctl_busy = 1'b1;
        wr(16'h0000, 8'hF0);
        chk(cancel == 1'b0, "R9", int'(cancel), 0, "reset ignored during program");
        unlock(); wr(16'h0555, 8'hA0); wr(16'h0600, 8'h22);
        chk(pgm_start == 1'b0 && pgm_addr == 16'h0500, "R9",
            int'({pgm_start, pgm_addr}), 'h0500, "program ignored during program");
        cur_req = "R12";
        @(negedge clk);
        ctl_busy = 1'b0; wr_valid = 1'b1; wr_addr = 16'h0000; wr_data = 8'hF0;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(cancel == 1'b1, "R12", int'(cancel), 1, "write at busy release accepted");

        cur_req = "R10";
        unlock(); wr(16'h0555, 8'h80); unlock(); wr(16'h0555, 8'h10);
        ctl_busy = 1'b1;
        unlock(); wr(16'h0555, 8'h90);
        chk(mode == 2'd0 && !cancel, "R10", int'({cancel, mode}), 0, "command ignored in erase");
        wr(16'h0000, 8'hF0);
        chk(cancel == 1'b1, "R10", int'(cancel), 1, "reset aborts erase");
        ctl_busy = 1'b0;

        cur_req = "R11";
        ctl_error = 1'b1;
        unlock(); wr(16'h0555, 8'hA0); wr(16'h0700, 8'h33);
        chk(pgm_start == 1'b0, "R11", int'(pgm_start), 0, "program blocked by error");
        unlock(); wr(16'h0000, 8'hF0);
        chk(cancel == 1'b1, "R11", int'(cancel), 1, "reset clears error");
        ctl_error = 1'b0;
        unlock(); wr(16'h0555, 8'h20);
        ctl_error = 1'b1;
        wr(16'h0000, 8'hA0); wr(16'h0005, 8'h05);
        chk(pgm_start == 1'b0, "R11", int'(pgm_start), 0, "bypass program blocked by error");
        wr(16'h0000, 8'hF0);
        chk(cancel == 1'b1 && mode == 2'd2, "R11", int'({cancel, mode}), 'h6,
            "bypass reset keeps bypass");
        ctl_error = 1'b0;
        wr(16'h0000, 8'h90); wr(16'h0000, 8'h00);
        chk(mode == 2'd0, "R8", int'(mode), 0, "bypass exit after error");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule